// File: doc/BRIEF.md
# Texture Result Queue with Format Packing

This block sits between a texture unit and one shader processor. It holds filtered color results until the processor reads them. Each result arrives as four 16-bit channels plus a format flag. The flag selects one of two formats:

- 8-bit normalized color, which occupies one 32-bit slot.
- 16-bit float color, which is split into two 32-bit slots: the red/green word first, then the blue/alpha word.

The processor takes words one at a time, in arrival order, through a show-ahead read port.

The storage holds eight 32-bit slots. That is enough for four pixels of the widest format. The producer side uses a valid/ready handshake. Ready is raised only when the free slots can hold the whole pixel that is currently offered, so a two-word pixel is never split.

Top module: `texel_result_queue`

## Requirements
- R1: Synchronous active-high reset empties the queue: afterwards `rdValid` is 0, `rdData` is 0 and `inReady` is 1 for either format.
- R2: With `inIsHalf`=0 a pixel takes one slot read back as {A[7:0],B[7:0],G[7:0],R[7:0]}, red in bits 7:0.
- R3: With `inIsHalf`=1 a pixel takes two slots; the first read returns {G,R} (red in bits 15:0), the second returns {A,B} (blue in bits 15:0).
- R4: `inReady` is 1 only when the free slots are at least the offered pixel's size (1 for `inIsHalf`=0, 2 for `inIsHalf`=1).
- R5: Words are returned in strict arrival order across mixed formats.
- R6: A read (`rdEn` while `rdValid`=1) frees exactly one slot; `inReady` depends on occupancy at the start of the cycle, so a same-cycle read does not admit a pixel into a full queue.
- R7: `rdEn` while the queue is empty returns `rdValid`=0 and `rdData`=0 and changes no state.
- R8: The queue holds eight slots: eight 8-bit pixels or four 16-bit float pixels.
- R9: An accepted pixel and a read in the same cycle both take effect.
- R10: In 8-bit format the upper byte of every channel input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Pixel result offered |
| inReady | output | 1 | Room exists for the offered pixel |
| inIsHalf | input | 1 | 1 = 16-bit float format, 0 = 8-bit normalized |
| inRed | input | 16 | Red channel |
| inGreen | input | 16 | Green channel |
| inBlue | input | 16 | Blue channel |
| inAlpha | input | 16 | Alpha channel |
| rdEn | input | 1 | Consume the head word |
| rdValid | output | 1 | Head word present |
| rdData | output | 32 | Head word (0 when empty) |

## Verification
The bench covers the following corner cases and the faults each one exposes:

- **Full queue.** It fills the queue to seven slots and to eight. A design that admits a float pixel with only one slot left would tear it across a wrap or overwrite unread data.
- **Read and offer in the same cycle.** It offers a pixel while reading from a full queue. Logic that counts the pending read would accept a pixel the queue cannot yet hold.
- **Read while empty.** It reads an empty queue and then fills it to capacity. A counter that underflowed would show up as a wrong ready pattern.
- **Packing.** Mixed-format tables with non-zero upper bytes catch swapped halves, a wrong byte order and leaked upper bits.

// File: rtl/tq_pkg.sv
package tq_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic wrOne;      // write one packed 8-bit pixel word
    logic wrTwo;      // write RG and BA words of a float pixel
    logic pop;        // advance the head
    logic headValid;  // queue not empty
  } tqStrobe_t;
endpackage

// File: rtl/tq_ctrl.sv
module tq_ctrl #(
  parameter int SLOTS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inIsHalf,
  input  logic             rdEn,
  output logic             inReady,
  output logic             rdValid,
  output tq_pkg::tqStrobe_t strobe
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] freeSlots;
  logic [CNT_W-1:0] need;
  logic             accept;
  logic             pop;

  always_comb begin
    freeSlots = CNT_W'(SLOTS) - count;
    need      = inIsHalf ? CNT_W'(2) : CNT_W'(1);
    inReady   = (freeSlots >= need);
    accept    = inValid && inReady;
    pop       = rdEn && (count != '0);
    rdValid   = (count != '0);
    strobe.wrOne     = accept && !inIsHalf;
    strobe.wrTwo     = accept && inIsHalf;
    strobe.pop       = pop;
    strobe.headValid = rdValid;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + (accept ? need : '0) - (pop ? CNT_W'(1) : '0);
  end

  assert_reset_empty_R1: assert property (@(posedge clk) rst |=> (count == '0));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (count <= CNT_W'(SLOTS)));

  assert_half_blocked_R4: assert property (@(posedge clk) disable iff (rst)
    (inIsHalf && (count > CNT_W'(SLOTS - 2))) |-> !inReady);

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rdEn && (count == '0) && !(inValid && inReady)) |=> (count == '0));

  assert_single_pop_R6: assert property (@(posedge clk) disable iff (rst)
    (rdEn && (count != '0) && !(inValid && inReady)) |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/tq_datapath.sv
module tq_datapath #(
  parameter int SLOTS = 8,
  parameter int CH_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  tq_pkg::tqStrobe_t   strobe,
  input  logic [CH_W-1:0]     inRed,
  input  logic [CH_W-1:0]     inGreen,
  input  logic [CH_W-1:0]     inBlue,
  input  logic [CH_W-1:0]     inAlpha,
  output logic [2*CH_W-1:0]   rdData
);
  localparam int WORD_W   = 2 * CH_W;
  localparam int NARROW_W = CH_W / 2;
  localparam int PTR_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [WORD_W-1:0] slotMem [SLOTS];
  logic [PTR_W-1:0]  wrPtr, wrPtrNext1, rdPtr;
  logic [WORD_W-1:0] loWord, hiWord;

  function automatic logic [PTR_W-1:0] nextIdx(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SLOTS - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wrPtrNext1 = nextIdx(wrPtr);
    if (strobe.wrTwo) loWord = {inGreen, inRed};
    else loWord = {inAlpha[NARROW_W-1:0], inBlue[NARROW_W-1:0],
                   inGreen[NARROW_W-1:0], inRed[NARROW_W-1:0]};
    hiWord = {inAlpha, inBlue};
    rdData = strobe.headValid ? slotMem[rdPtr] : '0;
  end

  for (genvar i = 0; i < SLOTS; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if ((strobe.wrOne || strobe.wrTwo) && wrPtr == PTR_W'(i))
        slotMem[i] <= loWord;
      else if (strobe.wrTwo && wrPtrNext1 == PTR_W'(i))
        slotMem[i] <= hiWord;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrOne)      wrPtr <= wrPtrNext1;
      else if (strobe.wrTwo) wrPtr <= nextIdx(wrPtrNext1);
      if (strobe.pop)        rdPtr <= nextIdx(rdPtr);
    end
  end

  assert_empty_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    !strobe.headValid |-> (rdPtr == wrPtr));

  assert_pop_one_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.pop |=> (rdPtr == nextIdx($past(rdPtr))));
endmodule

// File: rtl/texel_result_queue.sv
module texel_result_queue #(
  parameter int SLOTS = 8,
  parameter int CH_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inIsHalf,
  input  logic [CH_W-1:0]   inRed,
  input  logic [CH_W-1:0]   inGreen,
  input  logic [CH_W-1:0]   inBlue,
  input  logic [CH_W-1:0]   inAlpha,
  input  logic              rdEn,
  output logic              rdValid,
  output logic [2*CH_W-1:0] rdData
);
  tq_pkg::tqStrobe_t strobe;

  tq_ctrl #(.SLOTS(SLOTS)) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inIsHalf(inIsHalf),
    .rdEn(rdEn), .inReady(inReady), .rdValid(rdValid), .strobe(strobe)
  );

  tq_datapath #(.SLOTS(SLOTS), .CH_W(CH_W)) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .inRed(inRed), .inGreen(inGreen),
    .inBlue(inBlue), .inAlpha(inAlpha), .rdData(rdData)
  );
endmodule

// File: tb/tb_texel_result_queue.sv
`timescale 1ns/1ps
module tb_texel_result_queue;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, inValid, inReady, inIsHalf, rdEn, rdValid;
  logic [15:0] inRed, inGreen, inBlue, inAlpha;
  logic [31:0] rdData;

  texel_result_queue dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inIsHalf(inIsHalf),
    .inRed(inRed), .inGreen(inGreen), .inBlue(inBlue), .inAlpha(inAlpha),
    .rdEn(rdEn), .rdValid(rdValid), .rdData(rdData)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ [0:255];
  int qHead = 0;
  int qTail = 0;

  // {half, R, G, B, A, exp0, exp1}
  localparam logic [128:0] VECS [4] = '{
    {1'b0, 16'hAB12, 16'hCD34, 16'hEF56, 16'h0178, 32'h78563412, 32'h0},
    {1'b1, 16'h3C00, 16'hC000, 16'h4500, 16'h3800, 32'hC0003C00, 32'h38004500},
    {1'b0, 16'h00FF, 16'h0000, 16'h0080, 16'h007F, 32'h7F8000FF, 32'h0},
    {1'b1, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 32'h22221111, 32'h44443333}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack8(input logic [15:0] r, g, b, a);
    return {a[7:0], b[7:0], g[7:0], r[7:0]};
  endfunction

  task automatic enq(input bit half, input logic [15:0] r, g, b, a);
    if (half) begin
      expQ[qTail] = {g, r}; qTail++;
      expQ[qTail] = {a, b}; qTail++;
    end else begin
      expQ[qTail] = pack8(r, g, b, a); qTail++;
    end
  endtask

  task automatic pushPix(input bit half, input logic [15:0] r, g, b, a,
                         input bit expReady, input string req);
    @(negedge clk);
    inIsHalf = half; inRed = r; inGreen = g; inBlue = b; inAlpha = a; inValid = 1'b1;
    #1;
    check(inReady == expReady, req, 32'(inReady), 32'(expReady));
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic popWord(input string req);
    @(negedge clk);
    #1;
    check(rdValid == 1'b1, {req, " valid"}, 32'(rdValid), 32'h1);
    check(rdData == expQ[qHead], req, rdData, expQ[qHead]);
    qHead++;
    rdEn = 1'b1;
    @(posedge clk);
    #1 rdEn = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; inIsHalf = 1'b0; rdEn = 1'b0;
    inRed = '0; inGreen = '0; inBlue = '0; inAlpha = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    @(negedge clk); #1;
    check(rdValid == 1'b0, "R1 rdValid", 32'(rdValid), 32'h0);
    check(rdData == 32'h0, "R1 rdData", rdData, 32'h0);
    check(inReady == 1'b1, "R1 ready narrow", 32'(inReady), 32'h1);
    inIsHalf = 1'b1; #1;
    check(inReady == 1'b1, "R1 ready half", 32'(inReady), 32'h1);

    // Table: R2 R3 R5 R10 packing and ordering
    for (int v = 0; v < 4; v++) begin
      pushPix(VECS[v][128], VECS[v][127:112], VECS[v][111:96], VECS[v][95:80],
              VECS[v][79:64], 1'b1, "R2/R3 table accept");
      expQ[qTail] = VECS[v][63:32]; qTail++;
      if (VECS[v][128]) begin expQ[qTail] = VECS[v][31:0]; qTail++; end
    end
    for (int w = 0; w < 6; w++) popWord("R5 R2 R3 R10 table word");
    @(negedge clk); #1;
    check(rdValid == 1'b0, "R5 drained", 32'(rdValid), 32'h0);

    // R7: read on empty
    rdEn = 1'b1;
    @(negedge clk); #1;
    check(rdValid == 1'b0 && rdData == 32'h0, "R7 empty read", rdData, 32'h0);
    @(posedge clk); #1 rdEn = 1'b0;

    // R8: four float pixels fit, R4: fifth does not
    for (int p = 0; p < 4; p++) begin
      pushPix(1'b1, 16'(p), 16'(p + 16), 16'(p + 32), 16'(p + 48), 1'b1, "R8 half fill");
      enq(1'b1, 16'(p), 16'(p + 16), 16'(p + 32), 16'(p + 48));
    end
    pushPix(1'b1, 16'h9999, 16'h9999, 16'h9999, 16'h9999, 1'b0, "R4 full half");
    pushPix(1'b0, 16'h9999, 16'h9999, 16'h9999, 16'h9999, 1'b0, "R4 full narrow");
    for (int w = 0; w < 8; w++) popWord("R8 half drain");

    // R4: seven occupied
    for (int p = 0; p < 7; p++) begin
      pushPix(1'b0, 16'(p + 1), 16'(p + 2), 16'(p + 3), 16'(p + 4), 1'b1, "R8 narrow fill");
      enq(1'b0, 16'(p + 1), 16'(p + 2), 16'(p + 3), 16'(p + 4));
    end
    pushPix(1'b1, 16'h5555, 16'h5555, 16'h5555, 16'h5555, 1'b0, "R4 one free half");
    pushPix(1'b0, 16'h00AA, 16'h00BB, 16'h00CC, 16'h00DD, 1'b1, "R4 one free narrow");
    enq(1'b0, 16'h00AA, 16'h00BB, 16'h00CC, 16'h00DD);

    // R6: full, offer and read together; offer refused
    @(negedge clk);
    inIsHalf = 1'b0; inRed = 16'h0EE; inGreen = 16'h0EE; inBlue = 16'h0EE; inAlpha = 16'h0EE;
    inValid = 1'b1; rdEn = 1'b1; #1;
    check(inReady == 1'b0, "R6 ready ignores same-cycle read", 32'(inReady), 32'h0);
    check(rdData == expQ[qHead], "R6 head", rdData, expQ[qHead]);
    qHead++;
    @(posedge clk); #1 inValid = 1'b0; rdEn = 1'b0;

    // R9: seven occupied, accept and read together
    @(negedge clk);
    inIsHalf = 1'b0; inRed = 16'h0011; inGreen = 16'h0022; inBlue = 16'h0033; inAlpha = 16'h0044;
    inValid = 1'b1; rdEn = 1'b1; #1;
    check(inReady == 1'b1, "R9 ready", 32'(inReady), 32'h1);
    check(rdData == expQ[qHead], "R9 head", rdData, expQ[qHead]);
    qHead++;
    enq(1'b0, 16'h0011, 16'h0022, 16'h0033, 16'h0044);
    @(posedge clk); #1 inValid = 1'b0; rdEn = 1'b0;
    @(negedge clk);
    inIsHalf = 1'b1; #1;
    check(inReady == 1'b0, "R9 still seven (half)", 32'(inReady), 32'h0);
    inIsHalf = 1'b0; #1;
    check(inReady == 1'b1, "R9 still seven (narrow)", 32'(inReady), 32'h1);
    for (int w = 0; w < 7; w++) popWord("R5 R9 final drain");
    @(negedge clk); #1;
    check(rdValid == 1'b0, "R6 final empty", 32'(rdValid), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule